// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block keeps the reservation state behind load-linked / store-conditional pairs for a data cache. It sits beside the cache controller. Each cycle the controller may report one completed write-class request as an operation code, a line address and the ID of the requester that issued it. A load-linked completion records a reservation for its line, owned by that requester. A later store-conditional from the same requester to the same line succeeds only if that reservation is still in place. A one-bit result goes back to the processor as the conditional store's extra data value.

Reservations are held in a small set of slots, each holding a valid bit, a line address and an owner ID. Three things remove a reservation: any store-conditional to its line, an ordinary write by the owning requester, and an invalidate or eviction notice from the cache for that line. Locked read-modify-write pairs also pass through the block. The locked read raises a queue block for its line, and the matching locked write drops it. Cache storage and the coherence protocol live elsewhere.

Top module: `resv_mon`

## Requirements
- R1: A completion with operation code 1 (load-linked) leaves its line reserved for its requester and reports success 1 one cycle later.
- R2: A completion with operation code 2 (store-conditional) reports success 1 only if, at that cycle, its line is reserved by the same requester; otherwise it reports 0.
- R3: Each completion raises `rspValid` for exactly one cycle, one clock after `cmplValid`; with no completion `rspValid` and `rspSuccess` are 0.
- R4: A store-conditional removes any reservation on its line, whoever owns it and whether or not it succeeded.
- R5: Operation codes 0, 3, 4, 5, 6 and 7 are ordinary writes. They report success 1, and they remove a reservation on their line only when the requester owns it. A reservation owned by another requester survives them.
- R6: A load-linked to a line that is already reserved changes that reservation's owner and takes no new slot.
- R7: A load-linked to an unreserved line takes the slot allocated longest ago, in round-robin order from slot 0 after reset, and discards whatever that slot held.
- R8: Operation code 3 (locked read) sets `qBlock` and loads `qBlockLine` with its line. Operation code 4 (locked write) clears `qBlock` only when its line equals `qBlockLine`; otherwise `qBlock` is unchanged.
- R9: `invValid` removes any reservation on `invLine`, and this takes precedence over a load-linked to the same line in the same cycle.
- R10: After reset no line is reserved, `rspValid` is 0 and `qBlock` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmplValid | input | 1 | A write-class request completed this cycle |
| cmplOp | input | 3 | Operation code of the completed request |
| cmplLine | input | LINE_W | Line address of the completed request |
| cmplReq | input | ID_W | Requester ID of the completed request |
| invValid | input | 1 | Invalidate/eviction notice for a line |
| invLine | input | LINE_W | Line address being invalidated |
| rspValid | output | 1 | Result of the previous cycle's completion is valid |
| rspSuccess | output | 1 | Extra data value returned to the processor (1 success, 0 fail) |
| qBlock | output | 1 | Request queue is blocked for `qBlockLine` |
| qBlockLine | output | LINE_W | Line for which the queue is blocked |

## Verification
Every result of this block is registered once. The success flag, the response strobe and the queue block for a completion presented before clock edge N all appear after edge N. The reservation change from that completion decides the result of a completion presented before edge N+1. The bench drives each completion on a falling edge, samples all four outputs at the next falling edge, and updates its reference model of the slots, the round-robin pointer and the block register at that same point. A check therefore never looks at a value one register early or late. Directed sequences cover slot replacement, ownership, invalidate collisions and block line matching before a long random run.

// File: rtl/resv_mon_pkg.sv
package resv_mon_pkg;

  // Completion operation codes (see brief, R1/R2/R5/R8)
  typedef enum logic [2:0] {
    OP_STORE  = 3'd0,
    OP_LL     = 3'd1,
    OP_SC     = 3'd2,
    OP_LKRD   = 3'd3,
    OP_LKWR   = 3'd4,
    OP_RMWRD  = 3'd5,
    OP_FLUSH  = 3'd6,
    OP_OTHER  = 3'd7
  } cmplOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic fire;       // a completion is being processed
    logic setLock;    // load-linked: create or retarget reservation
    logic condStore;  // store-conditional: evaluate and clear line
    logic plainWr;    // ordinary write: clear own reservation
    logic blkSet;     // locked read: block queue
    logic blkClr;     // locked write: release queue
  } resvStrobe_t;

endpackage

// File: rtl/resv_mon_ctrl.sv
module resv_mon_ctrl
  import resv_mon_pkg::*;
(
  input  logic        cmplValid,
  input  logic [2:0]  cmplOp,
  output resvStrobe_t stb
);

  cmplOp_e opDec;

  always_comb begin
    opDec = cmplOp_e'(cmplOp);
    stb   = '0;
    stb.fire = cmplValid;
    if (cmplValid) begin
      unique case (opDec)
        OP_LL:   stb.setLock   = 1'b1;
        OP_SC:   stb.condStore = 1'b1;
        OP_LKRD: begin
          stb.plainWr = 1'b1;
          stb.blkSet  = 1'b1;
        end
        OP_LKWR: begin
          stb.plainWr = 1'b1;
          stb.blkClr  = 1'b1;
        end
        default: stb.plainWr = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/resv_mon_datapath.sv
module resv_mon_datapath
  import resv_mon_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int LINE_W    = 26,
  parameter int ID_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  resvStrobe_t       stb,
  input  logic [LINE_W-1:0] cmplLine,
  input  logic [ID_W-1:0]   cmplReq,
  input  logic              invValid,
  input  logic [LINE_W-1:0] invLine,
  output logic              rspValid,
  output logic              rspSuccess,
  output logic              qBlock,
  output logic [LINE_W-1:0] qBlockLine
);

  localparam int PTR_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(NUM_SLOTS - 1);

  logic [NUM_SLOTS-1:0] slotV, nV;
  logic [LINE_W-1:0]    slotLine [NUM_SLOTS];
  logic [LINE_W-1:0]    nLine    [NUM_SLOTS];
  logic [ID_W-1:0]      slotOwn  [NUM_SLOTS];
  logic [ID_W-1:0]      nOwn     [NUM_SLOTS];
  logic [PTR_W-1:0]     allocPtr, nPtr;

  logic [NUM_SLOTS-1:0] lineHit, ownHit;
  logic anyHit, anyOwn;

  // Per-slot match logic
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gMatch
    assign lineHit[g] = slotV[g] && (slotLine[g] == cmplLine);
    assign ownHit[g]  = lineHit[g] && (slotOwn[g] == cmplReq);
  end

  assign anyHit = |lineHit;
  assign anyOwn = |ownHit;

  // Next reservation state
  always_comb begin
    nV   = slotV;
    nPtr = allocPtr;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      nLine[i] = slotLine[i];
      nOwn[i]  = slotOwn[i];
    end
    if (stb.fire) begin
      if (stb.setLock) begin
        if (anyHit) begin
          for (int i = 0; i < NUM_SLOTS; i++)
            if (lineHit[i]) nOwn[i] = cmplReq;
        end else begin
          nV[allocPtr]    = 1'b1;
          nLine[allocPtr] = cmplLine;
          nOwn[allocPtr]  = cmplReq;
          nPtr = (allocPtr == LAST_SLOT) ? '0 : allocPtr + 1'b1;
        end
      end
      if (stb.condStore) begin
        for (int i = 0; i < NUM_SLOTS; i++)
          if (lineHit[i]) nV[i] = 1'b0;
      end
      if (stb.plainWr) begin
        for (int i = 0; i < NUM_SLOTS; i++)
          if (ownHit[i]) nV[i] = 1'b0;
      end
    end
    if (invValid) begin
      for (int i = 0; i < NUM_SLOTS; i++)
        if (nV[i] && (nLine[i] == invLine)) nV[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotV    <= '0;
      allocPtr <= '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
        slotLine[i] <= '0;
        slotOwn[i]  <= '0;
      end
    end else begin
      slotV    <= nV;
      allocPtr <= nPtr;
      for (int i = 0; i < NUM_SLOTS; i++) begin
        slotLine[i] <= nLine[i];
        slotOwn[i]  <= nOwn[i];
      end
    end
  end

  // Response and queue block registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspSuccess <= 1'b0;
      qBlock     <= 1'b0;
      qBlockLine <= '0;
    end else begin
      rspValid   <= stb.fire;
      rspSuccess <= stb.fire && (!stb.condStore || anyOwn);
      if (stb.fire && stb.blkSet) begin
        qBlock     <= 1'b1;
        qBlockLine <= cmplLine;
      end else if (stb.fire && stb.blkClr && qBlock && (qBlockLine == cmplLine)) begin
        qBlock <= 1'b0;
      end
    end
  end

  // ---------------- assertions ----------------
  function automatic logic lineHeld(input logic [LINE_W-1:0] ln);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (slotV[i] && slotLine[i] == ln) r = 1'b1;
    return r;
  endfunction

  function automatic logic lineHeldBy(input logic [LINE_W-1:0] ln, input logic [ID_W-1:0] id);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (slotV[i] && slotLine[i] == ln && slotOwn[i] == id) r = 1'b1;
    return r;
  endfunction

  logic dupLine;
  always_comb begin
    dupLine = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++)
      for (int j = i + 1; j < NUM_SLOTS; j++)
        if (slotV[i] && slotV[j] && slotLine[i] == slotLine[j]) dupLine = 1'b1;
  end

  AST_LL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.fire && stb.setLock && !(invValid && invLine == cmplLine))
      |=> lineHeldBy($past(cmplLine), $past(cmplReq))); // R1

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    stb.fire |=> rspValid); // R3

  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !stb.fire |=> (!rspValid && !rspSuccess)); // R3

  AST_SC_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.fire && stb.condStore) |=> !lineHeld($past(cmplLine))); // R4

  AST_PLAIN_OK: assert property (@(posedge clk) disable iff (!rstN)
    (stb.fire && !stb.condStore) |=> rspSuccess); // R5

  AST_LINE_UNIQUE: assert property (@(posedge clk) disable iff (!rstN)
    !dupLine); // R6

  AST_BLK_SET: assert property (@(posedge clk) disable iff (!rstN)
    (stb.fire && stb.blkSet) |=> (qBlock && qBlockLine == $past(cmplLine))); // R8

  AST_INV_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    invValid |=> !lineHeld($past(invLine))); // R9

endmodule

// File: rtl/resv_mon.sv
module resv_mon
  import resv_mon_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int LINE_W    = 26,
  parameter int ID_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmplValid,
  input  logic [2:0]        cmplOp,
  input  logic [LINE_W-1:0] cmplLine,
  input  logic [ID_W-1:0]   cmplReq,
  input  logic              invValid,
  input  logic [LINE_W-1:0] invLine,
  output logic              rspValid,
  output logic              rspSuccess,
  output logic              qBlock,
  output logic [LINE_W-1:0] qBlockLine
);

  resvStrobe_t stb;

  resv_mon_ctrl u_ctrl (
    .cmplValid (cmplValid),
    .cmplOp    (cmplOp),
    .stb       (stb)
  );

  resv_mon_datapath #(
    .NUM_SLOTS (NUM_SLOTS),
    .LINE_W    (LINE_W),
    .ID_W      (ID_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .cmplLine   (cmplLine),
    .cmplReq    (cmplReq),
    .invValid   (invValid),
    .invLine    (invLine),
    .rspValid   (rspValid),
    .rspSuccess (rspSuccess),
    .qBlock     (qBlock),
    .qBlockLine (qBlockLine)
  );

  AST_RST_CLEAN: assert property (@(posedge clk)
    !rstN |=> (!rspValid && !qBlock)); // R10

endmodule

// File: tb/resv_mon_tb_top.sv
`timescale 1ns/1ps
module resv_mon_tb_top;

  localparam int NS = 4;
  localparam int LW = 26;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmplValid = 1'b0;
  logic [2:0]    cmplOp = '0;
  logic [LW-1:0] cmplLine = '0;
  logic [IW-1:0] cmplReq = '0;
  logic          invValid = 1'b0;
  logic [LW-1:0] invLine = '0;
  logic          rspValid, rspSuccess, qBlock;
  logic [LW-1:0] qBlockLine;

  always #2 clk = ~clk;

  resv_mon #(.NUM_SLOTS(NS), .LINE_W(LW), .ID_W(IW)) dut_i (
    .clk(clk), .rstN(rstN), .cmplValid(cmplValid), .cmplOp(cmplOp),
    .cmplLine(cmplLine), .cmplReq(cmplReq), .invValid(invValid), .invLine(invLine),
    .rspValid(rspValid), .rspSuccess(rspSuccess), .qBlock(qBlock), .qBlockLine(qBlockLine)
  );

  // reference model
  logic          mV   [NS];
  logic [LW-1:0] mLine[NS];
  logic [IW-1:0] mOwn [NS];
  int            mPtr;
  logic          mB;
  logic [LW-1:0] mBL;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int findLine(input logic [LW-1:0] ln);
    for (int i = 0; i < NS; i++) if (mV[i] && mLine[i] == ln) return i;
    return -1;
  endfunction

  function automatic string tagFor(input logic v, input logic [2:0] o);
    if (!v) return "R3";
    case (o)
      3'd1: return "R1";
      3'd2: return "R2";
      3'd3, 3'd4: return "R8";
      default: return "R5";
    endcase
  endfunction

  // Drive one cycle at a falling edge, check at the next falling edge.
  task automatic step(input logic v, input logic [2:0] o, input logic [LW-1:0] ln,
                      input logic [IW-1:0] rq, input logic iv, input logic [LW-1:0] il,
                      input string tag);
    logic expS;
    int k;
    expS = 1'b0;
    if (v) begin
      expS = 1'b1;
      k = findLine(ln);
      if (o == 3'd2) expS = (k >= 0) && (mOwn[k] == rq);
      case (o)
        3'd1: begin
          if (k >= 0) mOwn[k] = rq;
          else begin
            mV[mPtr] = 1'b1; mLine[mPtr] = ln; mOwn[mPtr] = rq;
            mPtr = (mPtr + 1) % NS;
          end
        end
        3'd2: if (k >= 0) mV[k] = 1'b0;
        default: if (k >= 0 && mOwn[k] == rq) mV[k] = 1'b0;
      endcase
      if (o == 3'd3) begin mB = 1'b1; mBL = ln; end
      else if (o == 3'd4 && mB && mBL == ln) mB = 1'b0;
    end
    if (iv) begin
      k = findLine(il);
      if (k >= 0) mV[k] = 1'b0;
    end
    cmplValid = v; cmplOp = o; cmplLine = ln; cmplReq = rq;
    invValid = iv; invLine = il;
    @(negedge clk);
    cmplValid = 1'b0; invValid = 1'b0;
    chk({tag, " rspValid"}, 32'(rspValid), 32'(v));
    chk({tag, " rspSuccess"}, 32'(rspSuccess), 32'(expS));
    chk({tag, " qBlock"}, 32'(qBlock), 32'(mB));
    if (mB) chk({tag, " qBlockLine"}, 32'(qBlockLine), 32'(mBL));
  endtask

  task automatic ll(input int ln, input int rq, input string tag);
    step(1, 3'd1, LW'(ln), IW'(rq), 0, '0, tag);
  endtask
  task automatic sc(input int ln, input int rq, input string tag);
    step(1, 3'd2, LW'(ln), IW'(rq), 0, '0, tag);
  endtask
  task automatic wr(input int ln, input int rq, input string tag);
    step(1, 3'd0, LW'(ln), IW'(rq), 0, '0, tag);
  endtask

  initial begin : watchdog
    #(4 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int unsigned seedv;
    for (int i = 0; i < NS; i++) begin mV[i] = 0; mLine[i] = '0; mOwn[i] = '0; end
    mPtr = 0; mB = 0; mBL = '0;
    seedv = $urandom(32'd4242);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 rspValid", 32'(rspValid), 0);
    chk("R10 qBlock", 32'(qBlock), 0);
    sc(5, 1, "R10");                    // no reservation: fail
    // R1 / R2
    ll(1, 1, "R1"); sc(1, 1, "R2");
    sc(1, 1, "R4");                     // cleared by previous SC
    // R4: failed SC also clears
    ll(2, 1, "R1"); sc(2, 2, "R4"); sc(2, 1, "R4");
    // R5: other requester's write keeps, own write clears
    ll(3, 1, "R1"); wr(3, 2, "R5"); sc(3, 1, "R5");
    ll(3, 1, "R1"); wr(3, 1, "R5"); sc(3, 1, "R5");
    // R6: retarget owner
    ll(4, 1, "R6"); ll(4, 2, "R6"); sc(4, 2, "R6");
    // R7: oldest slot replaced
    for (int i = 0; i < NS + 1; i++) ll(10 + i, 0, "R7");
    sc(10, 0, "R7"); sc(11, 0, "R7");
    // R9: invalidate alone and colliding with LL
    ll(6, 2, "R1");
    step(0, 3'd0, '0, '0, 1, LW'(6), "R9");
    sc(6, 2, "R9");
    step(1, 3'd1, LW'(7), IW'(3), 1, LW'(7), "R9");
    sc(7, 3, "R9");
    // R8: queue block
    step(1, 3'd3, LW'(8), IW'(1), 0, '0, "R8");
    step(1, 3'd4, LW'(9), IW'(1), 0, '0, "R8");
    step(1, 3'd4, LW'(8), IW'(1), 0, '0, "R8");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic v, iv;
      logic [2:0] o;
      v  = ($urandom % 10) != 0;
      o  = 3'($urandom % 8);
      if (($urandom % 3) == 0) o = 3'd1;
      iv = ($urandom % 10) == 0;
      step(v, o, LW'($urandom % 6), IW'($urandom % 4), iv, LW'($urandom % 6), tagFor(v, o));
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule